// File: doc/BRIEF.md
# NAND Page Hamming Parity Generator

This block builds a Hamming-style check code over the bytes moving between a host and a NAND page. It handles them in chunks of 256 bytes. Every byte taken in changes two kinds of parity. Line parity tracks the bits of the byte's index inside its chunk. Column parity tracks the position of each bit inside the byte. With 8 index bits and 3 bit-position bits, a chunk needs 22 parity bits, so a 512-byte page main area produces two separate 22-bit codes. An internal byte counter picks which code a byte updates: the counter's top bit selects the chunk.

The host controls accumulation with three commands. Clear zeroes both codes and the byte counter. Start opens accumulation, beginning with the next cycle. Stop closes it, so bytes sent after the main area (such as the spare bytes) leave the result alone. Both codes are visible at all times on one flat output.

A compare port takes a stored code and a chunk select. It XORs the stored code with the computed code to form a syndrome, then classifies the result as one of four outcomes: clean, a single correctable data bit (with its byte index and bit position), an error inside the stored code itself, or uncorrectable. The block only reports this outcome. It does not repair any data.

Top module: `necc_gen`

## Requirements
- R1: After reset, `codeOut` is all zero and `accumOn` is 0. With `cmpCode` at zero, `cmpStatus` reads 0 (clean).
- R2: A cycle with both `startCmd` and `clearCmd` high has these effects: the codes and byte counter are zeroed, and `accumOn` is 1 from the next cycle on. A valid byte in that same cycle is not accumulated, but valid bytes in later cycles are.
- R3: While `accumOn` is 0, valid bytes leave `codeOut` unchanged.
- R4: After a cycle with `stopCmd` high, `accumOn` is 0. No byte in that cycle or in any later cycle changes `codeOut`. Stop takes priority over start.
- R5: Column parity: for k in 0..2, code bit 2k+1 is the XOR of every accumulated data bit whose bit position has bit k set, and code bit 2k is the XOR of every accumulated data bit whose bit position has bit k clear.
- R6: Line parity: for j in 0..7, code bit 6+2j+1 is the XOR of every accumulated data bit whose byte index within the chunk has bit j set, and code bit 6+2j is the XOR of every accumulated data bit whose byte index has bit j clear.
- R7: The byte counter advances only on accumulated bytes. The first 256 accumulated bytes update chunk 0, which is `codeOut[21:0]`. The next 256 update chunk 1, which is `codeOut[43:22]`. Cycles with `dataValid` low are skipped.
- R8: If `cmpCode` equals the selected chunk's code, `cmpStatus` is 0.
- R9: If every one of the 11 pairs in the syndrome has exactly one bit set, `cmpStatus` is 1. In that case `errBit` is made of syndrome bits {5,3,1}, and `errByte` is made of the odd bits {21,19,...,7}.
- R10: A syndrome with exactly one bit set gives `cmpStatus` 2 (the error is in the stored code).
- R11: Any other nonzero syndrome gives `cmpStatus` 3. Whenever `cmpStatus` is not 1, `errByte` and `errBit` are zero.
- R12: `clearCmd` without start zeroes the codes and the counter and leaves `accumOn` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clearCmd | input | 1 | Zero the codes and byte counter |
| startCmd | input | 1 | Open accumulation from the next cycle |
| stopCmd | input | 1 | Close accumulation at once |
| dataValid | input | 1 | Byte on dataIn is transferred this cycle |
| dataIn | input | 8 | Transferred byte |
| codeOut | output | 44 | Both chunk codes, chunk 0 in the low 22 bits |
| accumOn | output | 1 | Accumulation is open |
| cmpSel | input | 1 | Chunk selected for comparison |
| cmpCode | input | 22 | Stored code to compare against |
| cmpStatus | output | 2 | 0 clean, 1 correctable, 2 code-field error, 3 uncorrectable |
| errByte | output | 8 | Index of the bad byte within the chunk |
| errBit | output | 3 | Position of the bad bit within the byte |

## Verification
An accepted byte shows up in `codeOut` exactly one clock edge after the cycle that presents it. The same holds for clear, start and stop: their effect on `codeOut` and `accumOn` appears after one edge. The bench drives each cycle's inputs just after a falling edge and reads the outputs at the following falling edge, which is half a period after the rising edge that updated them. The compare outputs are combinational on the registered codes, so in the compare sweeps the bench changes `cmpCode` and reads the status a nanosecond later, with no clock edge in between.

// File: rtl/necc_pkg.sv
package necc_pkg;
  localparam int DATA_W      = 8;
  localparam int CHUNK_BYTES = 256;
  localparam int NUM_CHUNKS  = 2;

  typedef enum logic [1:0] {
    ST_CLEAN   = 2'd0,
    ST_CORRECT = 2'd1,
    ST_FIELD   = 2'd2,
    ST_UNCORR  = 2'd3
  } cmpStatus_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic accum;
  } ctrlStrobe_t;
endpackage

// File: rtl/necc_ctrl.sv
module necc_ctrl #(
  parameter int CHUNK_BYTES = necc_pkg::CHUNK_BYTES,
  parameter int NUM_CHUNKS  = necc_pkg::NUM_CHUNKS,
  localparam int IDX_W = $clog2(CHUNK_BYTES),
  localparam int SEL_W = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     clearCmd,
  input  logic                     startCmd,
  input  logic                     stopCmd,
  input  logic                     dataValid,
  output necc_pkg::ctrlStrobe_t    strobe,
  output logic [IDX_W-1:0]         byteIdx,
  output logic [SEL_W-1:0]         chunkSel,
  output logic                     accumOn
);
  localparam int CNT_W = IDX_W + SEL_W;

  logic             enReg;
  logic [CNT_W-1:0] byteCnt;
  logic             takeByte;

  // stop and clear both gate the byte of their own cycle
  assign takeByte = enReg && dataValid && !stopCmd && !clearCmd;

  always_comb begin
    strobe          = '0;
    strobe.clearAll = clearCmd;
    strobe.accum    = takeByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg <= 1'b0;
    end else if (stopCmd) begin
      enReg <= 1'b0;
    end else if (startCmd) begin
      enReg <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt <= '0;
    end else if (clearCmd) begin
      byteCnt <= '0;
    end else if (takeByte) begin
      byteCnt <= byteCnt + 1'b1;
    end
  end

  assign byteIdx  = byteCnt[IDX_W-1:0];
  assign chunkSel = byteCnt[CNT_W-1:IDX_W];
  assign accumOn  = enReg;
endmodule

// File: rtl/necc_datapath.sv
module necc_datapath #(
  parameter int DATA_W      = necc_pkg::DATA_W,
  parameter int CHUNK_BYTES = necc_pkg::CHUNK_BYTES,
  parameter int NUM_CHUNKS  = necc_pkg::NUM_CHUNKS,
  localparam int COL_W  = $clog2(DATA_W),
  localparam int IDX_W  = $clog2(CHUNK_BYTES),
  localparam int SEL_W  = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1,
  localparam int CODE_W = 2 * (COL_W + IDX_W)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  necc_pkg::ctrlStrobe_t        strobe,
  input  logic [IDX_W-1:0]             byteIdx,
  input  logic [SEL_W-1:0]             chunkSel,
  input  logic [DATA_W-1:0]            dataIn,
  output logic [NUM_CHUNKS*CODE_W-1:0] codeFlat
);
  // lanes whose bit position has bit k set
  function automatic logic [DATA_W-1:0] laneMask(input int k);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int b = 0; b < DATA_W; b++) begin
      m[b] = ((b >> k) & 1) != 0;
    end
    return m;
  endfunction

  logic [CODE_W-1:0] contrib;
  logic              rowPar;

  assign rowPar = ^dataIn;

  always_comb begin
    contrib = '0;
    for (int k = 0; k < COL_W; k++) begin
      contrib[2*k+1] = ^(dataIn & laneMask(k));
      contrib[2*k]   = ^(dataIn & ~laneMask(k));
    end
    for (int j = 0; j < IDX_W; j++) begin
      contrib[2*(COL_W+j)+1] = rowPar & byteIdx[j];
      contrib[2*(COL_W+j)]   = rowPar & ~byteIdx[j];
    end
  end

  for (genvar c = 0; c < NUM_CHUNKS; c++) begin : g_chunk
    logic [CODE_W-1:0] codeReg;
    logic              hit;

    assign hit = strobe.accum && (chunkSel == SEL_W'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        codeReg <= '0;
      end else if (strobe.clearAll) begin
        codeReg <= '0;
      end else if (hit) begin
        codeReg <= codeReg ^ contrib;
      end
    end

    assign codeFlat[c*CODE_W +: CODE_W] = codeReg;
  end
endmodule

// File: rtl/necc_compare.sv
module necc_compare #(
  parameter int DATA_W      = necc_pkg::DATA_W,
  parameter int CHUNK_BYTES = necc_pkg::CHUNK_BYTES,
  parameter int NUM_CHUNKS  = necc_pkg::NUM_CHUNKS,
  localparam int COL_W  = $clog2(DATA_W),
  localparam int IDX_W  = $clog2(CHUNK_BYTES),
  localparam int SEL_W  = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1,
  localparam int CODE_W = 2 * (COL_W + IDX_W),
  localparam int PAIRS  = COL_W + IDX_W
) (
  input  logic [NUM_CHUNKS*CODE_W-1:0] codeFlat,
  input  logic [SEL_W-1:0]             cmpSel,
  input  logic [CODE_W-1:0]            cmpCode,
  output necc_pkg::cmpStatus_e         status,
  output logic [IDX_W-1:0]             errByte,
  output logic [COL_W-1:0]             errBit
);
  logic [CODE_W-1:0] selCode;
  logic [CODE_W-1:0] syn;
  logic [PAIRS-1:0]  pairOne;
  logic              oneBit;

  always_comb begin
    selCode = '0;
    for (int c = 0; c < NUM_CHUNKS; c++) begin
      if (cmpSel == SEL_W'(c)) selCode = codeFlat[c*CODE_W +: CODE_W];
    end
  end

  assign syn    = cmpCode ^ selCode;
  assign oneBit = (syn != '0) && ((syn & (syn - 1'b1)) == '0);

  always_comb begin
    for (int p = 0; p < PAIRS; p++) begin
      pairOne[p] = syn[2*p] ^ syn[2*p+1];
    end
  end

  always_comb begin
    status  = necc_pkg::ST_UNCORR;
    errByte = '0;
    errBit  = '0;
    if (syn == '0) begin
      status = necc_pkg::ST_CLEAN;
    end else if (&pairOne) begin
      status = necc_pkg::ST_CORRECT;
      for (int k = 0; k < COL_W; k++) errBit[k] = syn[2*k+1];
      for (int j = 0; j < IDX_W; j++) errByte[j] = syn[2*(COL_W+j)+1];
    end else if (oneBit) begin
      status = necc_pkg::ST_FIELD;
    end
  end
endmodule

// File: rtl/necc_gen.sv
module necc_gen #(
  parameter int DATA_W      = necc_pkg::DATA_W,
  parameter int CHUNK_BYTES = necc_pkg::CHUNK_BYTES,
  parameter int NUM_CHUNKS  = necc_pkg::NUM_CHUNKS,
  localparam int COL_W  = $clog2(DATA_W),
  localparam int IDX_W  = $clog2(CHUNK_BYTES),
  localparam int SEL_W  = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1,
  localparam int CODE_W = 2 * (COL_W + IDX_W)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         clearCmd,
  input  logic                         startCmd,
  input  logic                         stopCmd,
  input  logic                         dataValid,
  input  logic [DATA_W-1:0]            dataIn,
  output logic [NUM_CHUNKS*CODE_W-1:0] codeOut,
  output logic                         accumOn,
  input  logic [SEL_W-1:0]             cmpSel,
  input  logic [CODE_W-1:0]            cmpCode,
  output logic [1:0]                   cmpStatus,
  output logic [IDX_W-1:0]             errByte,
  output logic [COL_W-1:0]             errBit
);
  necc_pkg::ctrlStrobe_t strobe;
  necc_pkg::cmpStatus_e  statusE;
  logic [IDX_W-1:0]      byteIdx;
  logic [SEL_W-1:0]      chunkSel;

  necc_ctrl #(.CHUNK_BYTES(CHUNK_BYTES), .NUM_CHUNKS(NUM_CHUNKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .clearCmd(clearCmd), .startCmd(startCmd),
    .stopCmd(stopCmd), .dataValid(dataValid), .strobe(strobe),
    .byteIdx(byteIdx), .chunkSel(chunkSel), .accumOn(accumOn)
  );

  necc_datapath #(.DATA_W(DATA_W), .CHUNK_BYTES(CHUNK_BYTES), .NUM_CHUNKS(NUM_CHUNKS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteIdx(byteIdx),
    .chunkSel(chunkSel), .dataIn(dataIn), .codeFlat(codeOut)
  );

  necc_compare #(.DATA_W(DATA_W), .CHUNK_BYTES(CHUNK_BYTES), .NUM_CHUNKS(NUM_CHUNKS)) u_cmp (
    .codeFlat(codeOut), .cmpSel(cmpSel), .cmpCode(cmpCode),
    .status(statusE), .errByte(errByte), .errBit(errBit)
  );

  assign cmpStatus = statusE;
endmodule

// File: rtl/necc_gen_chk.sv
module necc_gen_chk #(
  parameter int DATA_W      = necc_pkg::DATA_W,
  parameter int CHUNK_BYTES = necc_pkg::CHUNK_BYTES,
  parameter int NUM_CHUNKS  = necc_pkg::NUM_CHUNKS,
  localparam int COL_W  = $clog2(DATA_W),
  localparam int IDX_W  = $clog2(CHUNK_BYTES),
  localparam int SEL_W  = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1,
  localparam int CODE_W = 2 * (COL_W + IDX_W)
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         clearCmd,
  input logic                         startCmd,
  input logic                         stopCmd,
  input logic [NUM_CHUNKS*CODE_W-1:0] codeOut,
  input logic                         accumOn,
  input logic [SEL_W-1:0]             cmpSel,
  input logic [CODE_W-1:0]            cmpCode,
  input logic [1:0]                   cmpStatus,
  input logic [IDX_W-1:0]             errByte,
  input logic [COL_W-1:0]             errBit
);
  logic [CODE_W-1:0] synChk;
  assign synChk = cmpCode ^ codeOut[int'(cmpSel)*CODE_W +: CODE_W];

  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    (startCmd && !stopCmd) |=> accumOn); // R2
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!accumOn && !clearCmd) |=> $stable(codeOut)); // R3
  AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    (stopCmd && !clearCmd) |=> (!accumOn && $stable(codeOut))); // R4
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    clearCmd |=> (codeOut == '0)); // R12
  AST_CORRECT_WEIGHT: assert property (@(posedge clk) disable iff (!rstN)
    (cmpStatus == 2'd1) |-> ($countones(synChk) == CODE_W/2)); // R9
  AST_FIELD_WEIGHT: assert property (@(posedge clk) disable iff (!rstN)
    (cmpStatus == 2'd2) |-> ($countones(synChk) == 1)); // R10
  AST_NO_POS_UNLESS_CORR: assert property (@(posedge clk) disable iff (!rstN)
    (cmpStatus != 2'd1) |-> (errByte == '0 && errBit == '0)); // R11
endmodule

bind necc_gen necc_gen_chk #(
  .DATA_W(DATA_W), .CHUNK_BYTES(CHUNK_BYTES), .NUM_CHUNKS(NUM_CHUNKS)
) u_chk (
  .clk(clk), .rstN(rstN), .clearCmd(clearCmd), .startCmd(startCmd),
  .stopCmd(stopCmd), .codeOut(codeOut), .accumOn(accumOn), .cmpSel(cmpSel),
  .cmpCode(cmpCode), .cmpStatus(cmpStatus), .errByte(errByte), .errBit(errBit)
);

// File: tb/test_necc_gen.sv
`timescale 1ns/1ps
module test_necc_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clearCmd = 1'b0, startCmd = 1'b0, stopCmd = 1'b0, dataValid = 1'b0;
  logic [7:0]  dataIn = '0;
  logic [43:0] codeOut;
  logic        accumOn;
  logic        cmpSel = 1'b0;
  logic [21:0] cmpCode = '0;
  logic [1:0]  cmpStatus;
  logic [7:0]  errByte;
  logic [2:0]  errBit;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [21:0] mCode [2];
  int  mCnt = 0;
  bit  mEn = 0;

  always #10 clk = ~clk;

  necc_gen i_necc_gen (
    .clk(clk), .rstN(rstN), .clearCmd(clearCmd), .startCmd(startCmd),
    .stopCmd(stopCmd), .dataValid(dataValid), .dataIn(dataIn),
    .codeOut(codeOut), .accumOn(accumOn), .cmpSel(cmpSel), .cmpCode(cmpCode),
    .cmpStatus(cmpStatus), .errByte(errByte), .errBit(errBit)
  );

  // parity contribution of one byte, straight from the bit definitions
  function automatic logic [21:0] refContrib(input int idx, input logic [7:0] d);
    logic [21:0] r;
    r = '0;
    for (int b = 0; b < 8; b++) begin
      if (d[b]) begin
        for (int k = 0; k < 3; k++) r[2*k + ((b >> k) & 1)] ^= 1'b1;
        for (int j = 0; j < 8; j++) r[6 + 2*j + ((idx >> j) & 1)] ^= 1'b1;
      end
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: drive after a falling edge, return at the next falling edge
  task automatic cyc(input bit v, input logic [7:0] d, input bit clr, input bit st, input bit sp);
    dataValid = v; dataIn = d; clearCmd = clr; startCmd = st; stopCmd = sp;
    @(negedge clk);
    if (clr) begin
      mCode[0] = '0; mCode[1] = '0; mCnt = 0;
    end else if (mEn && v && !sp) begin
      mCode[mCnt / 256] ^= refContrib(mCnt % 256, d);
      mCnt = (mCnt + 1) % 512;
    end
    if (sp) mEn = 0;
    else if (st) mEn = 1;
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 29 + 7) ^ (i >> 3));
  endfunction

  task automatic sweepCompare(input int c);
    cmpSel = c[0];
    cmpCode = mCode[c]; #1;
    chk(cmpStatus == 2'd0, "R8 clean", 64'(cmpStatus), 0);
    for (int i = 0; i < 256; i++) begin
      for (int b = 0; b < 8; b++) begin
        cmpCode = mCode[c] ^ refContrib(i, 8'(1 << b)); #1;
        chk(cmpStatus == 2'd1 && errByte == 8'(i) && errBit == 3'(b), "R9 single data bit",
            {52'(cmpStatus), errByte, 1'b0, errBit}, {52'd1, 8'(i), 1'b0, 3'(b)});
      end
    end
    for (int p = 0; p < 22; p++) begin
      cmpCode = mCode[c] ^ (22'd1 << p); #1;
      chk(cmpStatus == 2'd2 && errByte == 0 && errBit == 0, "R10 code field bit",
          {52'(cmpStatus), errByte, 1'b0, errBit}, {52'd2, 12'd0});
    end
    cmpCode = mCode[c] ^ refContrib(0, 8'h01) ^ refContrib(5, 8'h08); #1;
    chk(cmpStatus == 2'd3 && errByte == 0 && errBit == 0, "R11 double data bit",
        {52'(cmpStatus), errByte, 1'b0, errBit}, {52'd3, 12'd0});
    cmpCode = mCode[c] ^ 22'h000003; #1;
    chk(cmpStatus == 2'd3, "R11 two bits same pair", 64'(cmpStatus), 3);
    cmpCode = mCode[c] ^ 22'h000041; #1;
    chk(cmpStatus == 2'd3, "R11 two field bits", 64'(cmpStatus), 3);
  endtask

  initial begin
    mCode[0] = '0; mCode[1] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(codeOut == '0, "R1 code zero", 64'(codeOut), 0);
    chk(accumOn == 1'b0, "R1 accum off", 64'(accumOn), 0);
    chk(cmpStatus == 2'd0, "R1 status clean", 64'(cmpStatus), 0);

    // R3: bytes while closed are ignored
    for (int i = 0; i < 10; i++) cyc(1, 8'hC3 ^ 8'(i), 0, 0, 0);
    chk(codeOut == '0, "R3 closed bytes ignored", 64'(codeOut), 0);

    // R2: start+clear with a byte in the same cycle
    cyc(1, 8'hFF, 1, 1, 0);
    chk(codeOut == '0 && accumOn, "R2 start cycle byte dropped", {19'd0, accumOn, codeOut}, {19'd0, 1'b1, 44'd0});
    cyc(1, 8'h01, 0, 0, 0);
    chk(codeOut == {22'd0, refContrib(0, 8'h01)}, "R2 R5 R6 first byte", 64'(codeOut), 64'({mCode[1], mCode[0]}));

    // R12: clear alone while open keeps accumulation open and restarts counter
    cyc(0, 8'h00, 1, 0, 0);
    chk(codeOut == '0 && accumOn, "R12 clear while open", {19'd0, accumOn, codeOut}, {19'd0, 1'b1, 44'd0});
    cyc(1, 8'h80, 0, 0, 0);
    chk(codeOut == {22'd0, refContrib(0, 8'h80)}, "R12 R5 counter restarted", 64'(codeOut), 64'({mCode[1], mCode[0]}));

    // full page with gaps
    cyc(0, 8'h00, 1, 0, 0);
    begin
      int n = 0;
      int cy = 0;
      while (n < 512) begin
        if (cy % 7 == 3) cyc(0, 8'hA5, 0, 0, 0);
        else begin cyc(1, pat(n), 0, 0, 0); n++; end
        cy++;
        if (n == 256 && cy % 7 != 3)
          chk(codeOut[43:22] == '0, "R7 chunk1 untouched at half", 64'(codeOut[43:22]), 0);
      end
    end
    chk(codeOut[21:0] == mCode[0], "R5 R6 R7 chunk0 code", 64'(codeOut[21:0]), 64'(mCode[0]));
    chk(codeOut[43:22] == mCode[1], "R5 R6 R7 chunk1 code", 64'(codeOut[43:22]), 64'(mCode[1]));

    // R4: stop with a byte in the same cycle, then bytes and a start-with-stop
    cyc(1, 8'h5A, 0, 0, 1);
    chk(codeOut == {mCode[1], mCode[0]} && !accumOn, "R4 stop cycle byte dropped",
        {19'd0, accumOn, codeOut}, {20'd0, mCode[1], mCode[0]});
    for (int i = 0; i < 16; i++) cyc(1, 8'h3C + 8'(i), 0, 0, 0);
    cyc(1, 8'h11, 0, 1, 1);
    cyc(1, 8'h22, 0, 0, 0);
    chk(codeOut == {mCode[1], mCode[0]} && !accumOn, "R4 frozen after stop",
        {19'd0, accumOn, codeOut}, {20'd0, mCode[1], mCode[0]});

    sweepCompare(0);
    sweepCompare(1);
    cmpCode = '0; cmpSel = 1'b0;

    // R12: clear alone while closed
    cyc(0, 8'h00, 1, 0, 0);
    chk(codeOut == '0 && !accumOn, "R12 clear while closed", {19'd0, accumOn, codeOut}, 0);

    // second pattern: 300 bytes of 0xFF spans the chunk boundary
    cyc(0, 8'h00, 0, 1, 0);
    for (int i = 0; i < 300; i++) cyc(1, 8'hFF, 0, 0, 0);
    chk(codeOut == {mCode[1], mCode[0]}, "R5 R6 R7 all-ones pattern", 64'(codeOut), 64'({mCode[1], mCode[0]}));

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule